// File: doc/BRIEF.md
# Programmable Range Loadable Counter

A small binary up-counter that walks through a configured window of values and then starts again from the bottom of that window. Inside it is a plain wrap-around counter with three controls: a synchronous clear, a parallel load and a count enable. Around that counter sits compare logic. When counting is enabled and the value equals the configured last value, the compare logic drives the load control, so that the next edge writes the configured first value instead of incrementing.

Two window shapes can be selected. In modulus mode the counter runs 0, 1, ..., m-1 and repeats. In span mode it runs a, a+1, ..., b and repeats. A setting outside the legal limits turns the compare off, and the block then behaves as a free-running counter that wraps at its full width. A terminal-count flag marks the enabled cycle in which the counter sits on its active last value.

The configuration inputs are meant to be set once and left alone. They are not registered, so a change acts on the very next comparison. The bench uses that to retarget the window while the counter is running.

Top module: `rng_counter`

## Requirements
- R1: While `clr` is 1, the next `cnt_q` is 0, whatever `cnt_en`, the mode or the current value. Clear outranks the reload.
- R2: While `clr` is 0, `cnt_en` is 1 and no reload applies, the next `cnt_q` is `cnt_q`+1 modulo 2^WIDTH.
- R3: While `clr` and `cnt_en` are both 0, `cnt_q` keeps its value.
- R4: Modulus mode is `span_mode`=0 with `lim_hi`=m. When 2 <= m <= 2^WIDTH-1, an enabled edge at `cnt_q`=m-1 loads 0, which gives the sequence 0 to m-1.
- R5: Span mode is `span_mode`=1 with `lim_lo`=a and `lim_hi`=b. When 0 < a < b < 2^WIDTH-1, an enabled edge at `cnt_q`=b loads a.
- R6: Any other setting (modulus m < 2, or span with a=0, a>=b or b=2^WIDTH-1) makes the block a plain counter. It passes through the configured end value without reloading and wraps from 2^WIDTH-1 to 0.
- R7: `term_cnt` is 1 exactly when `cnt_en` is 1 and `cnt_q` equals the active last value. That value is m-1 or b for a legal setting, and 2^WIDTH-1 otherwise.
- R8: A value outside the active window counts up normally, wraps through 0 if it is above the window, and enters the window from below without any jump.
- R9: Changing `span_mode`, `lim_lo` or `lim_hi` never changes `cnt_q` by itself. The new setting governs the next compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear to zero, highest priority |
| cnt_en | input | 1 | Count enable; also qualifies the reload and the terminal flag |
| span_mode | input | 1 | 0 = modulus mode, 1 = span mode |
| lim_lo | input | WIDTH | First value of the window in span mode; ignored in modulus mode |
| lim_hi | input | WIDTH | m in modulus mode, last value b in span mode |
| cnt_q | output | WIDTH | Registered count value |
| term_cnt | output | 1 | Terminal count flag, combinational |

## Verification
A wrong stored value appears on `cnt_q` at the next edge. A wrong compare result shows up one edge later: at the window end the counter either runs past it or jumps too early. The terminal flag is combinational, so a decode fault shows in the same cycle as the value that triggers it. Stepping the counter across every window edge, in both modes and with illegal settings, therefore exposes each fault within one or two cycles.

// File: rtl/rng_counter_pkg.sv
package rng_counter_pkg;

  typedef enum logic {
    MODE_MODULUS = 1'b0,
    MODE_SPAN    = 1'b1
  } win_mode_e;

  typedef struct packed {
    logic       legal;
    logic [3:0] first;
    logic [3:0] last;
  } win4_t;

endpackage

// File: rtl/rng_window.sv
module rng_window #(
  parameter int WIDTH = 4
) (
  input  logic             span_mode,
  input  logic [WIDTH-1:0] lim_lo,
  input  logic [WIDTH-1:0] lim_hi,
  output logic             legal,
  output logic [WIDTH-1:0] first_val,
  output logic [WIDTH-1:0] last_val
);
  import rng_counter_pkg::*;

  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO    = '0;
  localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};

  win_mode_e mode;
  logic      mod_ok;
  logic      span_ok;

  assign mode    = win_mode_e'(span_mode);
  assign mod_ok  = (lim_hi > ONE);
  assign span_ok = (lim_lo != ZERO) && (lim_lo < lim_hi) && (lim_hi != TOP_VAL);

  always_comb begin
    legal     = 1'b0;
    first_val = ZERO;
    last_val  = TOP_VAL;
    unique case (mode)
      MODE_MODULUS: begin
        if (mod_ok) begin
          legal    = 1'b1;
          last_val = lim_hi - ONE;
        end
      end
      MODE_SPAN: begin
        if (span_ok) begin
          legal     = 1'b1;
          first_val = lim_lo;
          last_val  = lim_hi;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rng_core.sv
module rng_core #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    if (clr)       q_nxt = '0;
    else if (load) q_nxt = load_val;
    else if (step) q_nxt = q + ONE;
    else           q_nxt = q;
  end

  always_ff @(posedge clk) begin
    q <= q_nxt;
  end

endmodule

// File: rtl/rng_compare.sv
module rng_compare #(
  parameter int WIDTH = 4
) (
  input  logic             cnt_en,
  input  logic             legal,
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] last_val,
  output logic             at_end,
  output logic             reload
);
  logic hit;

  assign hit    = (q == last_val);
  assign at_end = cnt_en & hit;
  assign reload = at_end & legal;

endmodule

// File: rtl/rng_counter.sv
module rng_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic             span_mode,
  input  logic [WIDTH-1:0] lim_lo,
  input  logic [WIDTH-1:0] lim_hi,
  output logic [WIDTH-1:0] cnt_q,
  output logic             term_cnt
);
  logic             legal;
  logic [WIDTH-1:0] first_val;
  logic [WIDTH-1:0] last_val;
  logic             reload;
  logic [WIDTH-1:0] q;

  rng_window #(.WIDTH(WIDTH)) u_win (
    .span_mode (span_mode),
    .lim_lo    (lim_lo),
    .lim_hi    (lim_hi),
    .legal     (legal),
    .first_val (first_val),
    .last_val  (last_val)
  );

  rng_compare #(.WIDTH(WIDTH)) u_cmp (
    .cnt_en   (cnt_en),
    .legal    (legal),
    .q        (q),
    .last_val (last_val),
    .at_end   (term_cnt),
    .reload   (reload)
  );

  rng_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .clr      (clr),
    .load     (reload),
    .step     (cnt_en),
    .load_val (first_val),
    .q        (q)
  );

  assign cnt_q = q;

endmodule

// File: rtl/rng_counter_chk.sv
module rng_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr,
  input logic             cnt_en,
  input logic             span_mode,
  input logic [WIDTH-1:0] lim_lo,
  input logic [WIDTH-1:0] lim_hi,
  input logic [WIDTH-1:0] cnt_q,
  input logic             term_cnt
);
  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | clr;

  logic span_legal;
  logic span_end;
  assign span_legal = span_mode && (lim_lo != '0) && (lim_lo < lim_hi) && (lim_hi != TOP_VAL);
  assign span_end   = span_legal && (cnt_q == lim_hi);

  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (cnt_q == '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !cnt_en) |=> $stable(cnt_q));

  a_r5_span_reload: assert property (@(posedge clk) disable iff (!armed)
    (!clr && cnt_en && span_end) |=> (cnt_q == $past(lim_lo)));

  a_r2_step_up: assert property (@(posedge clk) disable iff (!armed)
    (!clr && cnt_en && span_legal && (cnt_q != lim_hi)) |=> (cnt_q == $past(cnt_q) + ONE));

  a_r7_tc_needs_en: assert property (@(posedge clk) disable iff (!armed)
    term_cnt |-> cnt_en);

  a_r6_wrap_top: assert property (@(posedge clk) disable iff (!armed)
    (!clr && cnt_en && (cnt_q == TOP_VAL) && !span_mode && (lim_hi < 2'd2)) |=> (cnt_q == '0));

endmodule

bind rng_counter rng_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .clr       (clr),
  .cnt_en    (cnt_en),
  .span_mode (span_mode),
  .lim_lo    (lim_lo),
  .lim_hi    (lim_hi),
  .cnt_q     (cnt_q),
  .term_cnt  (term_cnt)
);

// File: tb/rng_counter_test.sv
module rng_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 38;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       cnt_en = 1'b0;
  logic       span_mode = 1'b0;
  logic [3:0] lim_lo = 4'd0;
  logic [3:0] lim_hi = 4'd0;
  logic [3:0] cnt_q;
  logic       term_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_counter #(.WIDTH(4)) uut (
    .clk(clk), .clr(clr), .cnt_en(cnt_en), .span_mode(span_mode),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .cnt_q(cnt_q), .term_cnt(term_cnt)
  );

  // {req[3:0], clr, en, mode, lo[3:0], hi[3:0], q_after[3:0], tc_before}
  localparam logic [19:0] VEC [NV] = '{
    {4'd2, 3'b010, 4'd0, 4'd6,  4'd1,  1'b0}, // R2 0->1, modulus 6
    {4'd2, 3'b010, 4'd0, 4'd6,  4'd2,  1'b0},
    {4'd2, 3'b010, 4'd0, 4'd6,  4'd3,  1'b0},
    {4'd2, 3'b010, 4'd0, 4'd6,  4'd4,  1'b0},
    {4'd2, 3'b010, 4'd0, 4'd6,  4'd5,  1'b0},
    {4'd4, 3'b010, 4'd0, 4'd6,  4'd0,  1'b1}, // R4 5 -> 0
    {4'd4, 3'b010, 4'd0, 4'd6,  4'd1,  1'b0},
    {4'd3, 3'b000, 4'd0, 4'd6,  4'd1,  1'b0}, // R3 hold
    {4'd8, 3'b011, 4'd5, 4'd11, 4'd2,  1'b0}, // R8 below span 5..11
    {4'd8, 3'b011, 4'd5, 4'd11, 4'd3,  1'b0},
    {4'd8, 3'b011, 4'd5, 4'd11, 4'd4,  1'b0},
    {4'd8, 3'b011, 4'd5, 4'd11, 4'd5,  1'b0},
    {4'd2, 3'b011, 4'd5, 4'd11, 4'd6,  1'b0},
    {4'd2, 3'b011, 4'd5, 4'd11, 4'd7,  1'b0},
    {4'd2, 3'b011, 4'd5, 4'd11, 4'd8,  1'b0},
    {4'd2, 3'b011, 4'd5, 4'd11, 4'd9,  1'b0},
    {4'd2, 3'b011, 4'd5, 4'd11, 4'd10, 1'b0},
    {4'd2, 3'b011, 4'd5, 4'd11, 4'd11, 1'b0},
    {4'd5, 3'b011, 4'd5, 4'd11, 4'd5,  1'b1}, // R5 11 -> 5
    {4'd5, 3'b011, 4'd5, 4'd11, 4'd6,  1'b0},
    {4'd3, 3'b001, 4'd5, 4'd11, 4'd6,  1'b0}, // R3 hold in span mode
    {4'd1, 3'b111, 4'd5, 4'd11, 4'd0,  1'b0}, // R1 clear while enabled
    {4'd6, 3'b011, 4'd0, 4'd3,  4'd1,  1'b0}, // R6 a=0 illegal
    {4'd6, 3'b011, 4'd0, 4'd3,  4'd2,  1'b0},
    {4'd6, 3'b011, 4'd0, 4'd3,  4'd3,  1'b0},
    {4'd6, 3'b011, 4'd0, 4'd3,  4'd4,  1'b0}, // R6 passes 3 without reload
    {4'd9, 3'b001, 4'd2, 4'd4,  4'd4,  1'b0}, // R9 retarget, no change
    {4'd9, 3'b011, 4'd2, 4'd4,  4'd2,  1'b1}, // R9 new end 4 -> load 2
    {4'd5, 3'b011, 4'd2, 4'd4,  4'd3,  1'b0},
    {4'd5, 3'b011, 4'd2, 4'd4,  4'd4,  1'b0},
    {4'd1, 3'b111, 4'd2, 4'd4,  4'd0,  1'b1}, // R1 clear beats reload
    {4'd4, 3'b010, 4'd0, 4'd2,  4'd1,  1'b0}, // R4 m=2
    {4'd4, 3'b010, 4'd0, 4'd2,  4'd0,  1'b1},
    {4'd4, 3'b010, 4'd0, 4'd2,  4'd1,  1'b0},
    {4'd7, 3'b000, 4'd0, 4'd2,  4'd1,  1'b0}, // R7 tc low, en low at end
    {4'd6, 3'b011, 4'd6, 4'd6,  4'd2,  1'b0}, // R6 a==b illegal
    {4'd4, 3'b010, 4'd7, 4'd3,  4'd0,  1'b1}, // R4 m=3, lo ignored
    {4'd1, 3'b100, 4'd0, 4'd3,  4'd0,  1'b0}  // R1 clear while idle
  };

  task automatic chk(input int req, input logic [3:0] act, input logic [3:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive at negedge, check tc, clock, check q
  task automatic step(input int req, input logic c, input logic e, input logic m,
                      input logic [3:0] lo, input logic [3:0] hi,
                      input logic [3:0] q_exp, input logic tc_exp);
    @(negedge clk);
    clr = c; cnt_en = e; span_mode = m; lim_lo = lo; lim_hi = hi;
    #1;
    chk(req, {3'b0, term_cnt}, {3'b0, tc_exp}, "term_cnt");
    @(posedge clk);
    #1;
    chk(req, cnt_q, q_exp, "cnt_q");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    @(posedge clk); @(posedge clk); #1;
    chk(1, cnt_q, 4'd0, "reset value");

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      step(int'(v[19:16]), v[15], v[14], v[13], v[12:9], v[8:5], v[4:1], v[0]);
    end

    // R6 / R7 plain wrap with illegal modulus m=1: 0..15 then 0, tc only at 15
    step(1, 1'b1, 1'b0, 1'b0, 4'd0, 4'd1, 4'd0, 1'b0);
    for (int k = 0; k < 16; k++) begin
      logic [3:0] nx;
      nx = 4'(k + 1);
      step(6, 1'b0, 1'b1, 1'b0, 4'd0, 4'd1, nx, (k == 15));
    end

    // R8 above-window value wraps through 0 into span 5..11
    step(1, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0);
    for (int k = 0; k < 13; k++) begin
      logic [3:0] nx;
      nx = 4'(k + 1);
      step(2, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0, nx, 1'b0);
    end
    step(8, 1'b0, 1'b1, 1'b1, 4'd5, 4'd11, 4'd14, 1'b0);
    step(8, 1'b0, 1'b1, 1'b1, 4'd5, 4'd11, 4'd15, 1'b0);
    step(8, 1'b0, 1'b1, 1'b1, 4'd5, 4'd11, 4'd0,  1'b0); // R7 no tc at 15
    step(8, 1'b0, 1'b1, 1'b1, 4'd5, 4'd11, 4'd1,  1'b0);

    // R6 span with b=15 illegal: 15 wraps to 0 with tc
    step(1, 1'b1, 1'b0, 1'b1, 4'd5, 4'd15, 4'd0, 1'b0);
    for (int k = 0; k < 15; k++) begin
      logic [3:0] nx;
      nx = 4'(k + 1);
      step(6, 1'b0, 1'b1, 1'b1, 4'd5, 4'd15, nx, 1'b0);
    end
    step(7, 1'b0, 1'b1, 1'b1, 4'd5, 4'd15, 4'd0, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule